// File: doc/BRIEF.md
# Segment Access Protection Checker

This block judges two kinds of protection request for a segmented memory unit. The first kind loads a segment register. The caller supplies a selector, the attributes of the descriptor that was already fetched for it, the current privilege level and the byte limit of the descriptor table. The checker decides whether that descriptor may be placed in the named register. The second kind is an operand reference through a segment register that is already loaded. For this kind the checker compares the access direction, the access size and the offset with the segment's type and limit.

Each accepted request gives, one clock later, a registered response. The response carries a valid strobe, a fault flag, an exception vector and an error code. The vector depends on the cause of the violation, and for some causes on whether the stack register is involved. When a load is refused because of its selector, the error code identifies that selector. When no selector is to blame, the error code is zero. Fetching descriptors and dispatching exceptions are left to neighbouring blocks.

Top module: `seg_guard`

## Requirements
- R1: A response strobe (`rsp_valid`) rises exactly one cycle after each cycle with `req_valid` high, and is low in every other cycle. While `rsp_valid` is low, `rsp_fault` is low. Reset clears both.
- R2: On a load with a non-null selector, if the last byte of the descriptor entry is beyond `tbl_limit`, the fault uses vector 13. The last byte is `{sel[15:3],3'b111}`, compared without sign.
- R3: A load whose descriptor type does not suit the destination faults with vector 13. CS accepts only code (`d_is_seg=1`, `d_exec=1`). SS accepts only writable data (`d_is_seg=1`, `d_exec=0`, `d_rw=1`). DS and ES accept data, or code with `d_rw=1` (readable). A system descriptor (`d_is_seg=0`) is refused everywhere.
- R4: A load that breaks the privilege rules faults with vector 13. Let `eff` be the larger of CPL and RPL, where RPL is `sel[1:0]`. For DS and ES the rule is `eff <= DPL`, except that readable conforming code (`d_conf=1`) is exempt. For SS the rule is RPL == CPL and DPL == CPL. For CS with conforming code the rule is DPL <= CPL; for other code it is RPL <= CPL and DPL == CPL.
- R5: A load of a descriptor with `d_present=0` faults with vector 12 when the destination is SS, and with vector 11 for any other destination.
- R6: A null selector is one with `sel[15:2]==0`. Loading it into DS or ES gives no fault, whatever the descriptor inputs hold. Loading it into CS or SS faults with vector 13 and error code 0.
- R7: A reference faults with vector 13 in three cases: a write to code, a read from code with `d_rw=0`, and a write to data with `d_rw=0`. Every reference fault reports error code 0.
- R8: A reference faults on its limit when either the offset or the last byte is above `d_limit`. The last byte is `acc_offset + acc_word`, taken modulo 2^16, so the carry is dropped. A limit fault uses vector 12 when the access goes through SS and vector 13 otherwise.
- R9: The load checks rank as table limit, then type, then privilege, then present. The reference checks rank as type, then limit. Only the highest-ranked violation sets the vector.
- R10: A response without a fault carries vector 0 and error code 0.
- R11: Every load fault other than a null-selector fault reports the selector with its two RPL bits cleared as the error code.

Register codes on `req_seg`: 0 = ES, 1 = CS, 2 = SS, 3 = DS. On `req_op`, 0 is a load and 1 is a reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = register load, 1 = operand reference |
| req_seg | input | 2 | Segment register: 0 ES, 1 CS, 2 SS, 3 DS |
| req_sel | input | 16 | Selector being loaded: index, table bit, RPL |
| cur_pl | input | 2 | Current privilege level |
| tbl_limit | input | 16 | Byte limit of the descriptor table |
| d_present | input | 1 | Descriptor present |
| d_is_seg | input | 1 | 1 = code or data segment, 0 = system descriptor |
| d_exec | input | 1 | 1 = code segment |
| d_conf | input | 1 | Conforming code |
| d_rw | input | 1 | Readable (code) or writable (data) |
| d_dpl | input | 2 | Descriptor privilege level |
| d_limit | input | 16 | Segment byte limit |
| acc_write | input | 1 | Reference is a write |
| acc_word | input | 1 | Reference is two bytes wide |
| acc_offset | input | 16 | Reference offset |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Violation found |
| rsp_vector | output | 8 | Exception vector (11, 12, 13 or 0) |
| rsp_errcode | output | 16 | Error code for the fault |

## Verification
The bench builds the checker with its default 16-bit selector and offset widths. With these widths the offset can wrap from 0xFFFF to 0x0000, which covers the dropped-carry case. The 13-bit index can go well past a small table limit. All four RPL, CPL and DPL values can be mixed, which covers the conforming and non-conforming privilege rules and the null-selector cases. The bench also stacks several violations on one load or reference, which tests the ranking between them.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;

    // destination / source segment register codes
    typedef enum logic [1:0] {
        SR_ES = 2'd0,
        SR_CS = 2'd1,
        SR_SS = 2'd2,
        SR_DS = 2'd3
    } segreg_e;

    localparam logic OP_LOAD = 1'b0;
    localparam logic OP_REF  = 1'b1;

    // selector layout
    localparam int RPL_W   = 2;
    localparam int IDX_LSB = 3;

    // exception vectors
    localparam int          VEC_W    = 8;
    localparam logic [7:0]  VEC_NONE = 8'd0;
    localparam logic [7:0]  VEC_ABS  = 8'd11;
    localparam logic [7:0]  VEC_STK  = 8'd12;
    localparam logic [7:0]  VEC_GP   = 8'd13;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_TABLE,
        CAUSE_TYPE,
        CAUSE_PRIV,
        CAUSE_ABSENT,
        CAUSE_NULL,
        CAUSE_ACCESS,
        CAUSE_LIMIT
    } cause_e;

    typedef struct packed {
        logic       present;
        logic       is_seg;
        logic       exec;
        logic       conf;
        logic       rw;
        logic [1:0] dpl;
    } dattr_t;

    function automatic logic [1:0] pl_max(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic cause_is_load(input cause_e c);
        return (c == CAUSE_TABLE) || (c == CAUSE_TYPE) ||
               (c == CAUSE_PRIV)  || (c == CAUSE_ABSENT);
    endfunction

endpackage

// File: rtl/seg_load_check.sv
module seg_load_check
    import seg_guard_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  segreg_e            seg,
    input  logic [SEL_W-1:0]   sel,
    input  logic [1:0]         cpl,
    input  logic [SEL_W-1:0]   tbl_limit,
    input  dattr_t             attr,
    output cause_e             cause,
    output logic               table_fault
);
    localparam int IDX_W = SEL_W - IDX_LSB;

    logic [SEL_W-1:0] entry_last;
    logic             is_null;
    logic             beyond;
    logic             type_ok;
    logic             priv_ok;
    logic [1:0]       rpl;
    logic [1:0]       eff;

    assign rpl        = sel[RPL_W-1:0];
    assign eff        = pl_max(cpl, rpl);
    assign entry_last = {sel[SEL_W-1 -: IDX_W], {IDX_LSB{1'b1}}};
    assign is_null    = (sel[SEL_W-1:RPL_W] == '0);
    assign beyond     = entry_last > tbl_limit;
    assign table_fault = beyond && !is_null;

    // allowed type per destination
    always_comb begin
        type_ok = 1'b0;
        if (attr.is_seg) begin
            unique case (seg)
                SR_CS:   type_ok = attr.exec;
                SR_SS:   type_ok = !attr.exec && attr.rw;
                default: type_ok = !attr.exec || attr.rw;
            endcase
        end
    end

    // privilege rules per destination
    always_comb begin
        unique case (seg)
            SR_CS: begin
                if (attr.conf) priv_ok = (attr.dpl <= cpl);
                else           priv_ok = (rpl <= cpl) && (attr.dpl == cpl);
            end
            SR_SS:   priv_ok = (rpl == cpl) && (attr.dpl == cpl);
            default: priv_ok = (attr.exec && attr.conf) || (eff <= attr.dpl);
        endcase
    end

    // ranked selection
    always_comb begin
        cause = CAUSE_NONE;
        if (is_null) begin
            if (seg == SR_CS || seg == SR_SS) cause = CAUSE_NULL;
        end else if (beyond) begin
            cause = CAUSE_TABLE;
        end else if (!type_ok) begin
            cause = CAUSE_TYPE;
        end else if (!priv_ok) begin
            cause = CAUSE_PRIV;
        end else if (!attr.present) begin
            cause = CAUSE_ABSENT;
        end
    end

endmodule

// File: rtl/seg_ref_check.sv
module seg_ref_check
    import seg_guard_pkg::*;
#(
    parameter int OFF_W = 16
) (
    input  logic             exec,
    input  logic             rw,
    input  logic [OFF_W-1:0] limit,
    input  logic             is_write,
    input  logic             is_word,
    input  logic [OFF_W-1:0] offset,
    output cause_e           cause
);
    logic [OFF_W-1:0] last_byte;
    logic             access_bad;
    logic             limit_bad;

    // carry out of the offset sum is dropped
    assign last_byte = offset + OFF_W'(is_word);

    always_comb begin
        if (exec) access_bad = is_write || !rw;
        else      access_bad = is_write && !rw;
    end

    assign limit_bad = (offset > limit) || (last_byte > limit);

    always_comb begin
        if (access_bad)     cause = CAUSE_ACCESS;
        else if (limit_bad) cause = CAUSE_LIMIT;
        else                cause = CAUSE_NONE;
    end

endmodule

// File: rtl/seg_fault_encode.sv
module seg_fault_encode
    import seg_guard_pkg::*;
#(
    parameter int SEL_W = 16
) (
    input  cause_e                  cause,
    input  segreg_e                 seg,
    input  logic [SEL_W-1:RPL_W]    sel_hi,
    output logic                    fault,
    output logic [VEC_W-1:0]        vector,
    output logic [SEL_W-1:0]        errcode
);
    logic stack_path;

    assign stack_path = (seg == SR_SS);

    always_comb begin
        fault = (cause != CAUSE_NONE);
        unique case (cause)
            CAUSE_NONE:   vector = VEC_NONE;
            CAUSE_ABSENT: vector = stack_path ? VEC_STK : VEC_ABS;
            CAUSE_LIMIT:  vector = stack_path ? VEC_STK : VEC_GP;
            default:      vector = VEC_GP;
        endcase
        errcode = cause_is_load(cause) ? {sel_hi, {RPL_W{1'b0}}} : '0;
    end

endmodule

// File: rtl/seg_guard.sv
module seg_guard
    import seg_guard_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int OFF_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_op,
    input  logic [1:0]       req_seg,
    input  logic [SEL_W-1:0] req_sel,
    input  logic [1:0]       cur_pl,
    input  logic [SEL_W-1:0] tbl_limit,
    input  logic             d_present,
    input  logic             d_is_seg,
    input  logic             d_exec,
    input  logic             d_conf,
    input  logic             d_rw,
    input  logic [1:0]       d_dpl,
    input  logic [OFF_W-1:0] d_limit,
    input  logic             acc_write,
    input  logic             acc_word,
    input  logic [OFF_W-1:0] acc_offset,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [7:0]       rsp_vector,
    output logic [SEL_W-1:0] rsp_errcode
);
    segreg_e          seg;
    dattr_t           attr;
    cause_e           ld_cause;
    cause_e           rf_cause;
    cause_e           sel_cause;
    logic             ld_table;
    logic             nx_fault;
    logic [VEC_W-1:0] nx_vector;
    logic [SEL_W-1:0] nx_err;

    assign seg  = segreg_e'(req_seg);
    assign attr = '{present: d_present, is_seg: d_is_seg, exec: d_exec,
                    conf: d_conf, rw: d_rw, dpl: d_dpl};

    seg_load_check #(.SEL_W(SEL_W)) u_load (
        .seg         (seg),
        .sel         (req_sel),
        .cpl         (cur_pl),
        .tbl_limit   (tbl_limit),
        .attr        (attr),
        .cause       (ld_cause),
        .table_fault (ld_table)
    );

    seg_ref_check #(.OFF_W(OFF_W)) u_ref (
        .exec     (d_exec),
        .rw       (d_rw),
        .limit    (d_limit),
        .is_write (acc_write),
        .is_word  (acc_word),
        .offset   (acc_offset),
        .cause    (rf_cause)
    );

    assign sel_cause = (req_op == OP_REF) ? rf_cause : ld_cause;

    seg_fault_encode #(.SEL_W(SEL_W)) u_enc (
        .cause   (sel_cause),
        .seg     (seg),
        .sel_hi  (req_sel[SEL_W-1:RPL_W]),
        .fault   (nx_fault),
        .vector  (nx_vector),
        .errcode (nx_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_fault   <= 1'b0;
            rsp_vector  <= '0;
            rsp_errcode <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault   <= nx_fault;
                rsp_vector  <= nx_vector;
                rsp_errcode <= nx_err;
            end else begin
                rsp_fault   <= 1'b0;
                rsp_vector  <= '0;
                rsp_errcode <= '0;
            end
        end
    end

    AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_NO_STRAY_RESP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid && !rsp_fault); // R1
    AST_TABLE_WINS: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_LOAD && ld_table |=>
        rsp_fault && rsp_vector == VEC_GP &&
        rsp_errcode == {$past(req_sel[SEL_W-1:RPL_W]), {RPL_W{1'b0}}}); // R2
    AST_ABSENT_VEC: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_LOAD && ld_cause == CAUSE_ABSENT |=>
        rsp_vector == (($past(req_seg) == 2'd2) ? VEC_STK : VEC_ABS)); // R5
    AST_REF_NO_SEL: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_REF |=> rsp_errcode == '0); // R7
    AST_STACK_LIMIT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_op == OP_REF && rf_cause == CAUSE_LIMIT && seg == SR_SS |=>
        rsp_fault && rsp_vector == VEC_STK); // R8
    AST_CLEAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_vector == '0 && rsp_errcode == '0); // R10

endmodule

// File: tb/seg_guard_test.sv
module seg_guard_test;

    typedef struct {
        logic        op;
        logic [1:0]  seg;
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic [15:0] tlim;
        logic        p, s, x, c, rw;
        logic [1:0]  dpl;
        logic [15:0] lim;
        logic        wr, wd;
        logic [15:0] off;
    } stim_t;

    typedef struct {
        logic        fault;
        logic [7:0]  vec;
        logic [15:0] err;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_op = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_sel = '0;
    logic [1:0]  cur_pl = '0;
    logic [15:0] tbl_limit = '0;
    logic        d_present = 1'b0, d_is_seg = 1'b0, d_exec = 1'b0, d_conf = 1'b0, d_rw = 1'b0;
    logic [1:0]  d_dpl = '0;
    logic [15:0] d_limit = '0;
    logic        acc_write = 1'b0, acc_word = 1'b0;
    logic [15:0] acc_offset = '0;
    logic        rsp_valid, rsp_fault;
    logic [7:0]  rsp_vector;
    logic [15:0] rsp_errcode;

    int   vectors = 0;
    int   miscompares = 0;
    exp_t pending[$];

    always #2 clk = ~clk;

    seg_guard uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_seg(req_seg), .req_sel(req_sel), .cur_pl(cur_pl), .tbl_limit(tbl_limit),
        .d_present(d_present), .d_is_seg(d_is_seg), .d_exec(d_exec), .d_conf(d_conf),
        .d_rw(d_rw), .d_dpl(d_dpl), .d_limit(d_limit), .acc_write(acc_write),
        .acc_word(acc_word), .acc_offset(acc_offset), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_vector(rsp_vector), .rsp_errcode(rsp_errcode)
    );

    // reference model written from the requirements
    function automatic exp_t model(stim_t t, string tag);
        exp_t        e;
        logic [15:0] last;
        logic [1:0]  rpl;
        logic [1:0]  eff;
        logic        tok;
        logic        pok;
        logic        bad;
        e.fault = 1'b0; e.vec = 8'd0; e.err = 16'd0; e.tag = tag;
        rpl = t.sel[1:0];
        eff = (t.cpl > rpl) ? t.cpl : rpl;
        if (t.op == 1'b0) begin
            if (t.sel[15:2] == 14'd0) begin
                if (t.seg == 2'd1 || t.seg == 2'd2) begin
                    e.fault = 1'b1; e.vec = 8'd13;
                end
            end else begin
                if (t.seg == 2'd1)      tok = t.s && t.x;
                else if (t.seg == 2'd2) tok = t.s && !t.x && t.rw;
                else                    tok = t.s && (!t.x || t.rw);
                if (t.seg == 2'd1)      pok = t.c ? (t.dpl <= t.cpl) : (rpl <= t.cpl && t.dpl == t.cpl);
                else if (t.seg == 2'd2) pok = (rpl == t.cpl) && (t.dpl == t.cpl);
                else                    pok = (t.x && t.c) || (eff <= t.dpl);
                bad = 1'b1;
                if ({t.sel[15:3], 3'b111} > t.tlim) e.vec = 8'd13;
                else if (!tok)                      e.vec = 8'd13;
                else if (!pok)                      e.vec = 8'd13;
                else if (!t.p)                      e.vec = (t.seg == 2'd2) ? 8'd12 : 8'd11;
                else                                bad = 1'b0;
                if (bad) begin
                    e.fault = 1'b1;
                    e.err = {t.sel[15:2], 2'b00};
                end
            end
        end else begin
            last = t.off + {15'd0, t.wd};
            if ((t.x && (t.wr || !t.rw)) || (!t.x && t.wr && !t.rw)) begin
                e.fault = 1'b1; e.vec = 8'd13;
            end else if (t.off > t.lim || last > t.lim) begin
                e.fault = 1'b1; e.vec = (t.seg == 2'd2) ? 8'd12 : 8'd13;
            end
        end
        return e;
    endfunction

    function automatic stim_t base_load();
        stim_t t;
        t.op = 1'b0; t.seg = 2'd3; t.sel = 16'h0010; t.cpl = 2'd0; t.tlim = 16'h00FF;
        t.p = 1'b1; t.s = 1'b1; t.x = 1'b0; t.c = 1'b0; t.rw = 1'b1; t.dpl = 2'd0;
        t.lim = 16'h0FFF; t.wr = 1'b0; t.wd = 1'b0; t.off = 16'h0000;
        return t;
    endfunction

    function automatic stim_t base_ref();
        stim_t t;
        t = base_load();
        t.op = 1'b1;
        return t;
    endfunction

    task automatic send(stim_t t, string tag);
        @(negedge clk);
        req_valid = 1'b1; req_op = t.op; req_seg = t.seg; req_sel = t.sel;
        cur_pl = t.cpl; tbl_limit = t.tlim; d_present = t.p; d_is_seg = t.s;
        d_exec = t.x; d_conf = t.c; d_rw = t.rw; d_dpl = t.dpl; d_limit = t.lim;
        acc_write = t.wr; acc_word = t.wd; acc_offset = t.off;
        pending.push_back(model(t, tag));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // monitor: compare each response against the queue
    always @(posedge clk) begin
        #1;
        if (!rst && rsp_valid) begin
            vectors++;
            if (pending.size() == 0) begin
                miscompares++;
                $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = pending.pop_front();
                if (rsp_fault !== e.fault || rsp_vector !== e.vec || rsp_errcode !== e.err) begin
                    miscompares++;
                    $display("FAIL %s actual fault=%0b vec=%0d err=%h expected fault=%0b vec=%0d err=%h",
                             e.tag, rsp_fault, rsp_vector, rsp_errcode, e.fault, e.vec, e.err);
                end
            end
        end else if (!rst && !rsp_valid && rsp_fault) begin
            vectors++;
            miscompares++;
            $display("FAIL R1 fault without strobe: actual fault=1 expected fault=0");
        end
    end

    task automatic run_all();
        stim_t t;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        vectors++;
        if (rsp_valid !== 1'b0 || rsp_fault !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset state: actual valid=%0b fault=%0b expected 0 0", rsp_valid, rsp_fault);
        end

        // R10 clean load
        t = base_load(); send(t, "R10 clean DS load");
        t.seg = 2'd2; send(t, "R10 clean SS load");
        // R2 table limit, R11 error code RPL cleared
        t = base_load(); t.sel = 16'h010B; t.dpl = 2'd3; send(t, "R2 R11 table overrun");
        t = base_load(); t.sel = 16'h00F8; t.tlim = 16'h00FF; send(t, "R2 last entry fits");
        t = base_load(); t.sel = 16'h0100; t.tlim = 16'h00FF; send(t, "R2 one past table");
        // R3 type matrix
        t = base_load(); t.seg = 2'd2; t.rw = 1'b0; send(t, "R3 read-only data into SS");
        t = base_load(); t.s = 1'b0; send(t, "R3 system into DS");
        t = base_load(); t.seg = 2'd0; t.s = 1'b0; send(t, "R3 system into ES");
        t = base_load(); t.x = 1'b1; t.rw = 1'b0; send(t, "R3 exec-only into DS");
        t = base_load(); t.seg = 2'd1; send(t, "R3 data into CS");
        t = base_load(); t.seg = 2'd2; t.x = 1'b1; t.rw = 1'b1; send(t, "R3 readable code into SS");
        t = base_load(); t.x = 1'b1; t.rw = 1'b1; send(t, "R3 readable code into DS ok");
        // R4 privilege
        t = base_load(); t.cpl = 2'd3; t.sel = 16'h0013; send(t, "R4 DS dpl below cpl");
        t = base_load(); t.dpl = 2'd3; t.sel = 16'h0013; send(t, "R4 DS dpl3 ok");
        t = base_load(); t.dpl = 2'd1; t.sel = 16'h0012; send(t, "R4 DS rpl above dpl");
        t = base_load(); t.seg = 2'd2; t.dpl = 2'd1; send(t, "R4 SS dpl not cpl");
        t = base_load(); t.seg = 2'd2; t.sel = 16'h0011; send(t, "R4 SS rpl not cpl");
        t = base_load(); t.seg = 2'd1; t.x = 1'b1; send(t, "R4 CS plain ok");
        t = base_load(); t.seg = 2'd1; t.x = 1'b1; t.c = 1'b1; t.cpl = 2'd3; t.sel = 16'h0013; send(t, "R4 CS conforming ok");
        t = base_load(); t.seg = 2'd1; t.x = 1'b1; t.c = 1'b1; t.dpl = 2'd3; send(t, "R4 CS conforming dpl high");
        t = base_load(); t.seg = 2'd1; t.x = 1'b1; t.cpl = 2'd2; t.sel = 16'h0012; send(t, "R4 CS plain dpl mismatch");
        t = base_load(); t.x = 1'b1; t.c = 1'b1; t.cpl = 2'd3; t.sel = 16'h0013; send(t, "R4 DS conforming code exempt");
        // R5 present
        t = base_load(); t.seg = 2'd2; t.p = 1'b0; send(t, "R5 absent into SS");
        t = base_load(); t.seg = 2'd0; t.p = 1'b0; send(t, "R5 absent into ES");
        t = base_load(); t.seg = 2'd1; t.x = 1'b1; t.p = 1'b0; send(t, "R5 absent into CS");
        // R9 ranking
        t = base_load(); t.seg = 2'd2; t.p = 1'b0; t.sel = 16'h0800; send(t, "R9 table before present");
        t = base_load(); t.seg = 2'd2; t.p = 1'b0; t.rw = 1'b0; send(t, "R9 type before present");
        t = base_load(); t.seg = 2'd0; t.p = 1'b0; t.cpl = 2'd3; t.sel = 16'h0013; send(t, "R9 privilege before present");
        // R6 null selector
        t = base_load(); t.sel = 16'h0003; t.p = 1'b0; t.s = 1'b0; t.cpl = 2'd3; send(t, "R6 null into DS");
        t.seg = 2'd0; send(t, "R6 null into ES");
        t.seg = 2'd1; send(t, "R6 null into CS");
        t.seg = 2'd2; t.sel = 16'h0000; send(t, "R6 null into SS");
        idle(2);
        // R7 access type
        t = base_ref(); t.x = 1'b1; t.wr = 1'b1; send(t, "R7 write to code");
        t = base_ref(); t.x = 1'b1; t.rw = 1'b0; send(t, "R7 read exec-only");
        t = base_ref(); t.rw = 1'b0; t.wr = 1'b1; send(t, "R7 write read-only data");
        t = base_ref(); t.rw = 1'b0; send(t, "R7 read read-only data ok");
        // R8 limit
        t = base_ref(); t.lim = 16'h0010; t.off = 16'h0011; send(t, "R8 DS beyond limit");
        t.seg = 2'd2; send(t, "R8 SS beyond limit");
        t = base_ref(); t.lim = 16'h0010; t.off = 16'h0010; t.wd = 1'b1; send(t, "R8 word straddles limit");
        t = base_ref(); t.lim = 16'h0010; t.off = 16'h0010; send(t, "R8 byte at limit ok");
        t = base_ref(); t.lim = 16'hFFFF; t.off = 16'hFFFF; t.wd = 1'b1; send(t, "R8 wrap carry dropped");
        t = base_ref(); t.lim = 16'hFFFE; t.off = 16'hFFFF; t.wd = 1'b1; t.seg = 2'd2; send(t, "R8 SS top beyond limit");
        // R9 reference ranking
        t = base_ref(); t.seg = 2'd2; t.rw = 1'b0; t.wr = 1'b1; t.lim = 16'h0001; t.off = 16'h0100; send(t, "R9 access before limit");
        idle(3);
        repeat (3) @(posedge clk);
        #1;
        vectors++;
        if (pending.size() != 0) begin
            miscompares++;
            $display("FAIL R1 missing responses: actual left=%0d expected 0", pending.size());
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                vectors++;
                miscompares++;
                $display("FAIL R1 watchdog: actual hung expected done");
            end
        join_any
        disable fork;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule